// File: doc/BRIEF.md
# Execute-Stage Control-Flow Resolver

This block sits in the execute stage of a five-stage 32-bit pipeline and settles every change of control flow there. It receives the decoded opcode, function code and source-register number of the instruction in execute, together with the operand values after forwarding, the sign-extended 16-bit immediate, the 26-bit jump field and the current fetch program counter. From these it decides whether fetch must be steered to a new address. If so, it produces that address and asks for the two front pipeline registers to be emptied. For the jump-and-link form it also produces a write of the return address into the link register.

Two conditions stop the machine: a dedicated halt function code, and a register jump through register 31 while that register holds zero. When either appears, the block raises a halt request for that cycle. The request empties the front registers and also the execute/memory register. On the next clock edge a sticky halted flag is set, which keeps fetch from issuing while older instructions drain. The flag clears only on synchronous reset. All redirect, flush and link outputs are combinational from the execute-stage inputs.

Top module: `exec_ctl_resolver`

## Requirements
- R1: While reset is held, and at the first clock edge after it, `halted` is 0. With `in_valid` at 0 after reset, every other output is 0.
- R2: The class comes from the opcode. Opcode 0 is register-type, opcodes 2 and 3 are jumps, and every other opcode is immediate-type. An immediate-type opcode with upper three bits other than 000 produces no output. A register-type instruction whose function code is neither 6'b001000 nor 6'b001100 also produces no output.
- R3: For opcode 4, when `rs_val` equals `rt_val`, `redirect` is 1, `new_pc` = `fetch_pc` + (`imm_sext` << 2) - 4, and `flush_front` is 1. When they differ, every output stays 0.
- R4: Opcodes 1, 5, 6 and 7 branch in the same way, but only when `rs_val` differs from `rt_val`. When the operands are equal they produce no output.
- R5: Opcode 2 gives `redirect` = 1, `flush_front` = 1 and `new_pc` = `fetch_pc` + (zero-extended `jfield` << 2) - 4. It gives `link_we` = 0.
- R6: Opcode 3 gives the same redirect and flush as R5. In addition, `link_we` = 1, `link_dst` = 31 and `link_val` = `fetch_pc` - 4.
- R7: Opcode 0 with function 6'b001000 gives `redirect` = 1, `flush_front` = 1 and `new_pc` = `rs_val`. The exception is `rs_num` = 31 with `rs_val` = 0: then the instruction acts as the halt of R8 and gives no redirect.
- R8: Opcode 0 with function 6'b001100 gives `halt_now`, `flush_front` and `flush_exmem` all 1, with `redirect` at 0.
- R9: `halted` becomes 1 at the clock edge after `halt_now` and stays 1 until reset. While `halted` is 1, no instruction produces any output.
- R10: With `in_valid` at 0, no output is produced, whatever the other inputs are. `halted` keeps its value.
- R11: Whenever `redirect` or `link_we` is 0, the matching `new_pc`, `link_dst` and `link_val` are 0. `flush_exmem` is 1 only together with `halt_now`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Execute stage holds a real instruction |
| opcode | input | 6 | Decoded opcode |
| funct | input | 6 | Decoded function code |
| rs_num | input | 5 | Source register number |
| rs_val | input | 32 | Forwarded first operand |
| rt_val | input | 32 | Forwarded second operand |
| imm_sext | input | 32 | Sign-extended immediate |
| jfield | input | 26 | Jump address field |
| fetch_pc | input | 32 | Current fetch program counter |
| redirect | output | 1 | Fetch must take `new_pc` |
| new_pc | output | 32 | Redirect target |
| flush_front | output | 1 | Empty the fetch/decode and decode/execute registers |
| flush_exmem | output | 1 | Empty the execute/memory register |
| link_we | output | 1 | Write the link register |
| link_dst | output | 5 | Link destination register |
| link_val | output | 32 | Return address to write |
| halt_now | output | 1 | Halt condition seen this cycle |
| halted | output | 1 | Sticky halt flag |

## Verification
A wrong class decode or a wrong comparison polarity shows up in the same cycle as a missing or spurious `redirect`, or as an incorrect `new_pc`, because every such output is combinational. A halted flag that fails to set, or that clears by itself, is seen one edge later: a taken branch presented after the halt still redirects. A stuck flag shows up as silence after reset. The vectors therefore mix taken and not-taken cases for every branch polarity, and they include negative offsets and the largest jump field. They also include register jumps through register 31 both with a zero value and with a non-zero value.

// File: rtl/ctlres_pkg.sv
package ctlres_pkg;

    localparam int XLEN  = 32;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int REG_W = 5;
    localparam int JF_W  = 26;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;

    localparam logic [FN_W-1:0] FN_JR   = 6'b001000;
    localparam logic [FN_W-1:0] FN_HALT = 6'b001100;

    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [2:0] {
        CK_NONE   = 3'd0,
        CK_BRANCH = 3'd1,
        CK_JUMP   = 3'd2,
        CK_JLINK  = 3'd3,
        CK_JREG   = 3'd4,
        CK_HALT   = 3'd5
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e kind;
        logic      want_equal;
    } ctl_dec_t;

    function automatic logic is_branch_opc(input logic [OPC_W-1:0] opc);
        return (opc[OPC_W-1 -: 3] == 3'b000) && (opc != OPC_RTYPE)
               && (opc != OPC_JMP) && (opc != OPC_JAL);
    endfunction

endpackage

// File: rtl/ctlres_decode.sv
module ctlres_decode
    import ctlres_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output ctl_dec_t         dec
);
    always_comb begin
        dec.kind       = CK_NONE;
        dec.want_equal = (opcode == OPC_BEQ);
        if (opcode == OPC_RTYPE) begin
            if (funct == FN_JR)
                dec.kind = CK_JREG;
            else if (funct == FN_HALT)
                dec.kind = CK_HALT;
        end else if (opcode == OPC_JMP) begin
            dec.kind = CK_JUMP;
        end else if (opcode == OPC_JAL) begin
            dec.kind = CK_JLINK;
        end else if (is_branch_opc(opcode)) begin
            dec.kind = CK_BRANCH;
        end
    end
endmodule

// File: rtl/ctlres_target.sv
module ctlres_target #(
    parameter int XLEN = 32,
    parameter int JF_W = 26
) (
    input  logic [XLEN-1:0] fetch_pc,
    input  logic [XLEN-1:0] imm_sext,
    input  logic [JF_W-1:0] jfield,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            want_equal,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] jmp_target,
    output logic [XLEN-1:0] ret_addr,
    output logic            br_taken
);
    localparam int PAD_W = XLEN - JF_W;
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    logic [XLEN-1:0] jf_ext;
    logic            ops_equal;

    assign jf_ext     = {{PAD_W{1'b0}}, jfield};
    assign ops_equal  = (rs_val == rt_val);
    assign ret_addr   = fetch_pc - WORD;
    assign br_target  = ret_addr + (imm_sext << 2);
    assign jmp_target = ret_addr + (jf_ext << 2);
    assign br_taken   = ~(ops_equal ^ want_equal);
endmodule

// File: rtl/ctlres_halt.sv
module ctlres_halt (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic halted_o
);
    always_ff @(posedge clk) begin
        if (rst)
            halted_o <= 1'b0;
        else if (set_i)
            halted_o <= 1'b1;
    end

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> halted_o);

    assert_halt_sets_R9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> halted_o);
endmodule

// File: rtl/exec_ctl_resolver.sv
module exec_ctl_resolver
    import ctlres_pkg::*;
#(
    parameter int XW = ctlres_pkg::XLEN,
    parameter int JW = ctlres_pkg::JF_W,
    parameter int RW = ctlres_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FN_W-1:0]   funct,
    input  logic [RW-1:0]     rs_num,
    input  logic [XW-1:0]     rs_val,
    input  logic [XW-1:0]     rt_val,
    input  logic [XW-1:0]     imm_sext,
    input  logic [JW-1:0]     jfield,
    input  logic [XW-1:0]     fetch_pc,
    output logic              redirect,
    output logic [XW-1:0]     new_pc,
    output logic              flush_front,
    output logic              flush_exmem,
    output logic              link_we,
    output logic [RW-1:0]     link_dst,
    output logic [XW-1:0]     link_val,
    output logic              halt_now,
    output logic              halted
);
    localparam logic [RW-1:0] LINK_IDX = RW'(LINK_REG);

    ctl_dec_t        dec;
    logic [XW-1:0]   br_target, jmp_target, ret_addr;
    logic            br_taken;
    logic            active;
    logic            jr_zero_link;

    ctlres_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .dec    (dec)
    );

    ctlres_target #(.XLEN(XW), .JF_W(JW)) u_tgt (
        .fetch_pc   (fetch_pc),
        .imm_sext   (imm_sext),
        .jfield     (jfield),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .want_equal (dec.want_equal),
        .br_target  (br_target),
        .jmp_target (jmp_target),
        .ret_addr   (ret_addr),
        .br_taken   (br_taken)
    );

    assign active       = in_valid && !halted;
    assign jr_zero_link = (rs_num == LINK_IDX) && (rs_val == '0);

    always_comb begin
        redirect = 1'b0;
        new_pc   = '0;
        link_we  = 1'b0;
        link_dst = '0;
        link_val = '0;
        halt_now = 1'b0;
        if (active) begin
            unique case (dec.kind)
                CK_BRANCH: begin
                    redirect = br_taken;
                    new_pc   = br_taken ? br_target : '0;
                end
                CK_JUMP: begin
                    redirect = 1'b1;
                    new_pc   = jmp_target;
                end
                CK_JLINK: begin
                    redirect = 1'b1;
                    new_pc   = jmp_target;
                    link_we  = 1'b1;
                    link_dst = LINK_IDX;
                    link_val = ret_addr;
                end
                CK_JREG: begin
                    if (jr_zero_link) begin
                        halt_now = 1'b1;
                    end else begin
                        redirect = 1'b1;
                        new_pc   = rs_val;
                    end
                end
                CK_HALT: halt_now = 1'b1;
                default: ;
            endcase
        end
    end

    assign flush_front = redirect | halt_now;
    assign flush_exmem = halt_now;

    ctlres_halt u_halt (
        .clk      (clk),
        .rst      (rst),
        .set_i    (halt_now),
        .halted_o (halted)
    );

    assert_bubble_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !(redirect || link_we || halt_now || flush_front));

    assert_quiet_when_halted_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(redirect || link_we || halt_now));

    assert_link_value_R6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_dst == LINK_IDX) && (link_val == fetch_pc - XW'(4))
                    && redirect);

    assert_halt_no_redirect_R8: assert property (@(posedge clk) disable iff (rst)
        halt_now |-> !redirect && flush_exmem && flush_front);

    assert_jr_target_R7: assert property (@(posedge clk) disable iff (rst)
        (redirect && opcode == OPC_RTYPE) |-> (new_pc == rs_val));
endmodule

// File: tb/sim_exec_ctl_resolver.sv
module sim_exec_ctl_resolver;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [5:0]  opcode, funct;
    logic [4:0]  rs_num;
    logic [31:0] rs_val, rt_val, imm_sext, fetch_pc;
    logic [25:0] jfield;
    logic        redirect, flush_front, flush_exmem, link_we, halt_now, halted;
    logic [31:0] new_pc, link_val;
    logic [4:0]  link_dst;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exec_ctl_resolver u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .funct(funct),
        .rs_num(rs_num), .rs_val(rs_val), .rt_val(rt_val), .imm_sext(imm_sext),
        .jfield(jfield), .fetch_pc(fetch_pc), .redirect(redirect), .new_pc(new_pc),
        .flush_front(flush_front), .flush_exmem(flush_exmem), .link_we(link_we),
        .link_dst(link_dst), .link_val(link_val), .halt_now(halt_now), .halted(halted)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        vld;
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [4:0]  rsn;
        logic [31:0] rsv;
        logic [31:0] rtv;
        logic [31:0] imm;
        logic [25:0] jf;
        logic [31:0] pc;
        logic        e_red;
        logic [31:0] e_pc;
        logic        e_lnk;
        logic [31:0] e_lval;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{"R3",  1, 6'd4, 6'd0, 5'd1, 32'd5, 32'd5, 32'd3,          26'd0, 32'h1000, 1, 32'h1008, 0, 0},
        '{"R3",  1, 6'd4, 6'd0, 5'd1, 32'd5, 32'd6, 32'd3,          26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R3",  1, 6'd4, 6'd0, 5'd1, 32'd7, 32'd7, 32'hFFFF_FFFE,  26'd0, 32'h1000, 1, 32'h0FF4, 0, 0},
        '{"R4",  1, 6'd5, 6'd0, 5'd1, 32'd1, 32'd2, 32'd1,          26'd0, 32'h1000, 1, 32'h1000, 0, 0},
        '{"R4",  1, 6'd5, 6'd0, 5'd1, 32'd9, 32'd9, 32'd1,          26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R4",  1, 6'd1, 6'd0, 5'd1, 32'd0, 32'd3, 32'd2,          26'd0, 32'h1000, 1, 32'h1004, 0, 0},
        '{"R4",  1, 6'd7, 6'd0, 5'd1, 32'd4, 32'd4, 32'd2,          26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R4",  1, 6'd6, 6'd0, 5'd1, 32'd4, 32'd8, 32'hFFFF_FFFF,  26'd0, 32'h1000, 1, 32'h0FF8, 0, 0},
        '{"R5",  1, 6'd2, 6'd0, 5'd1, 32'd0, 32'd0, 32'd0,       26'h10, 32'h1000, 1, 32'h103C, 0, 0},
        '{"R5",  1, 6'd2, 6'd0, 5'd1, 32'd0, 32'd0, 32'd0, 26'h3FF_FFFF, 32'h1000, 1, 32'h1000_0FF8, 0, 0},
        '{"R6",  1, 6'd3, 6'd0, 5'd1, 32'd0, 32'd0, 32'd0,        26'd4, 32'h2000, 1, 32'h200C, 1, 32'h1FFC},
        '{"R7",  1, 6'd0, 6'h08, 5'd8,  32'h4000, 32'd0, 32'd0,   26'd0, 32'h1000, 1, 32'h4000, 0, 0},
        '{"R7",  1, 6'd0, 6'h08, 5'd31, 32'h88,   32'd0, 32'd0,   26'd0, 32'h1000, 1, 32'h88,   0, 0},
        '{"R7",  1, 6'd0, 6'h08, 5'd9,  32'h0,    32'd0, 32'd0,   26'd0, 32'h1000, 1, 32'h0,    0, 0},
        '{"R2",  1, 6'd0, 6'h20, 5'd1, 32'd3, 32'd3, 32'd0,       26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R2",  1, 6'd8, 6'd0, 5'd1, 32'd3, 32'd3, 32'd4,        26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R2",  1, 6'h23, 6'd0, 5'd1, 32'd3, 32'd3, 32'd4,       26'd0, 32'h1000, 0, 32'h0,    0, 0},
        '{"R10", 0, 6'd4, 6'd0, 5'd1, 32'd5, 32'd5, 32'd3,        26'd0, 32'h1000, 0, 32'h0,    0, 0}
    };

    task automatic drive(input logic v, input logic [5:0] op, input logic [5:0] fn,
                         input logic [4:0] rsn, input logic [31:0] rsv, input logic [31:0] rtv,
                         input logic [31:0] imm, input logic [25:0] jf, input logic [31:0] pc);
        in_valid = v; opcode = op; funct = fn; rs_num = rsn; rs_val = rsv;
        rt_val = rtv; imm_sext = imm; jfield = jf; fetch_pc = pc;
    endtask

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] outs();
        return {23'd0, redirect, flush_front, flush_exmem, link_we, halt_now, halted,
                new_pc, link_dst, link_val, 27'd0};
    endfunction

    function automatic logic [127:0] mk(input logic red, input logic ff, input logic fe,
                                        input logic lw, input logic hn, input logic hd,
                                        input logic [31:0] pc, input logic [4:0] ld,
                                        input logic [31:0] lv);
        return {23'd0, red, ff, fe, lw, hn, hd, pc, ld, lv, 27'd0};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1: halted cleared during reset
        check("R1", {127'd0, halted}, 128'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        // R1: quiet after reset with no valid instruction
        check("R1", outs(), mk(0, 0, 0, 0, 0, 0, 0, 0, 0));

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].vld, VECS[i].op, VECS[i].fn, VECS[i].rsn, VECS[i].rsv,
                  VECS[i].rtv, VECS[i].imm, VECS[i].jf, VECS[i].pc);
            #2;
            // R11: address and link fields are zero when not in use
            check(string'(VECS[i].tag), outs(),
                  mk(VECS[i].e_red, VECS[i].e_red, 0, VECS[i].e_lnk, 0, 0,
                     VECS[i].e_pc, VECS[i].e_lnk ? 5'd31 : 5'd0, VECS[i].e_lval));
        end

        // R10: an invalid halt code does not set the flag
        @(negedge clk);
        drive(0, 6'd0, 6'h0C, 5'd0, 0, 0, 0, 0, 32'h1000);
        @(posedge clk);
        #2;
        check("R10", outs(), mk(0, 0, 0, 0, 0, 0, 0, 0, 0));

        // R8: halt function code
        @(negedge clk);
        drive(1, 6'd0, 6'h0C, 5'd0, 0, 0, 0, 0, 32'h1000);
        #2;
        check("R8", outs(), mk(0, 1, 1, 0, 1, 0, 0, 0, 0));
        @(posedge clk);
        #2;
        // R9: flag set one edge later; the held instruction now produces nothing
        check("R9", outs(), mk(0, 0, 0, 0, 0, 1, 0, 0, 0));
        @(negedge clk);
        drive(1, 6'd4, 6'd0, 5'd1, 32'd5, 32'd5, 32'd3, 0, 32'h1000);
        #2;
        check("R9", outs(), mk(0, 0, 0, 0, 0, 1, 0, 0, 0));
        @(negedge clk);
        drive(1, 6'd3, 6'd0, 5'd1, 0, 0, 0, 26'd4, 32'h2000);
        repeat (10) @(posedge clk);
        #2;
        check("R9", outs(), mk(0, 0, 0, 0, 0, 1, 0, 0, 0));

        // R9: only reset clears the flag
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R9", {127'd0, halted}, 128'd0);
        @(negedge clk);
        rst = 1'b0;

        // R7: register jump through register 31 holding zero halts
        @(negedge clk);
        drive(1, 6'd0, 6'h08, 5'd31, 32'd0, 0, 0, 0, 32'h3000);
        #2;
        check("R7", outs(), mk(0, 1, 1, 0, 1, 0, 0, 0, 0));
        @(posedge clk);
        #2;
        check("R7", {127'd0, halted}, 128'd1);

        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule